// File: doc/BRIEF.md
# Banded-Resolution Raster Timing Generator

This block generates the horizontal sync, vertical sync and blanking for an 800x600-class monitor raster. It runs on a 20 MHz master clock, which is half the standard rate, so each scan line carries 400 visible pixel periods. Along with the timing it emits two addresses for an external pixel memory. The first is a pixel column, one per clock. The second is a source line, which steps more slowly than the scan line when vertical repetition is in force.

Vertical repetition is set per screen band. A small band table holds up to eight entries, each giving a start scan line and a repeat factor. With this, a frame can show full 600-line detail at the top and halved or thirded detail further down. Software writes the table through a one-cycle write port. An edit is staged and becomes live only at the next frame boundary, so a frame never changes resolution partway through.

The returning 12-bit colour word is forced to black during blanking. It is then registered together with the sync and blank signals, so all of them leave on the same master clock edge. The horizontal and vertical porch and sync widths are elaboration parameters.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high, every output is held at zero: syncs, blank, frame pulse, colour, column and source line.
- R2: `hsync_o` is active high for H_SYNC clocks in every scan line. Its first active clock comes H_VIS+H_FP clocks after the line's first pixel.
- R3: `vsync_o` is active high for V_SYNC whole scan lines in every frame. It starts V_VIS+V_FP lines after the first visible line.
- R4: `blank_o` is high whenever the pixel column is H_VIS or more, or the scan line is V_VIS or more. It is low everywhere else.
- R5: All timing outputs lag the address outputs by two clocks. `rgb_i` is sampled one clock after its address is shown. `rgb_o` equals that sample AND-ed with the inverse of blank, and leaves on the same edge as `blank_o` and the syncs.
- R6: `frame_start_o` is high for exactly one clock per frame, on the first clock of scan line 0, aligned with the other timing outputs.
- R7: `pix_col_o` counts 0 to H_VIS+H_FP+H_SYNC+H_BP-1, advances one per clock and wraps to 0. The scan line advances at each wrap.
- R8: `src_line_o` is 0 during the first visible scan line of each frame. At the end of each visible line it advances by one once the current source line has been shown for its repeat factor of lines. Otherwise it holds.
- R9: The repeat factor for a visible scan line comes from the table entry with the greatest start line at or below that scan line. An entry with repeat 0 is disabled. On equal start lines, the higher index wins. If no enabled entry applies, the factor is 1. After reset, entry 0 is {start 0, repeat 1} and all other entries are disabled.
- R10: A table write (index `tbl_idx_i`, start `tbl_start_i`, repeat `tbl_rpt_i` when `tbl_wr_i` is high) has no effect on `src_line_o` until the first scan line of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_i | input | 1 | Band table write strobe |
| tbl_idx_i | input | 3 | Band entry index (log2 of BANDS) |
| tbl_start_i | input | 10 | Band start scan line |
| tbl_rpt_i | input | 4 | Band repeat factor, 0 disables the entry |
| rgb_i | input | 12 | Colour word returned by the pixel memory |
| pix_col_o | output | 10 | Pixel column address |
| src_line_o | output | 10 | Source line address |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| blank_o | output | 1 | Blanking, high outside the visible area |
| frame_start_o | output | 1 | One-clock pulse at the start of scan line 0 |
| rgb_o | output | 12 | Colour, zero while blanked |

## Verification
A corrupted horizontal counter shows up on `pix_col_o` on the very next clock. Two clocks later it also misplaces `hsync_o` and `blank_o`. A wrong repeat counter, band lookup or table commit does not change the syncs at all. It appears only on `src_line_o`, at the first line boundary where a source line advances too early or too late. A staged write that leaks into the live table therefore shows up before the frame it was written in has ended. The bench compares every output on every clock against a model built from the timing numbers and its own copy of the band entries. Band layouts exercise ties, disabled entries, the largest repeat factor and mid-frame writes.

// File: rtl/raster_pkg.sv
package raster_pkg;
    // One set of timing flags for a single pixel period.
    typedef struct packed {
        logic hsync;
        logic vsync;
        logic blank;
        logic fstart;
    } tim_t;
endpackage

// File: rtl/raster_axis_counter.sv
module raster_axis_counter #(
    parameter int TOTAL = 528,
    parameter int W     = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] LAST = W'(TOTAL - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap_o = en && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (en) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R7
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> cnt_q == '0);

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q));
endmodule

// File: rtl/raster_band_table.sv
module raster_band_table #(
    parameter int NUM = 8,
    parameter int LW  = 10,
    parameter int RW  = 4,
    parameter int IW  = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [LW-1:0] wr_start,
    input  logic [RW-1:0] wr_rpt,
    input  logic          commit,
    input  logic [LW-1:0] line_i,
    output logic [RW-1:0] rpt_o
);
    typedef struct packed {
        logic [NUM-1:0][LW-1:0] p_st;
        logic [NUM-1:0][RW-1:0] p_rp;
        logic [NUM-1:0][LW-1:0] a_st;
        logic [NUM-1:0][RW-1:0] a_rp;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic          found;
    logic [LW-1:0] best_st;

    // Next state: staged copy takes writes, live copy loads at frame end.
    always_comb begin
        tbl_d = tbl_q;
        if (commit) begin
            tbl_d.a_st = tbl_q.p_st;
            tbl_d.a_rp = tbl_q.p_rp;
        end
        for (int i = 0; i < NUM; i++) begin
            if (wr_en && (wr_idx == IW'(i))) begin
                tbl_d.p_st[i] = wr_start;
                tbl_d.p_rp[i] = wr_rpt;
            end
        end
    end

    // Lookup: greatest enabled start at or below the line, later index on ties.
    always_comb begin
        found   = 1'b0;
        best_st = '0;
        rpt_o   = RW'(1);
        for (int i = 0; i < NUM; i++) begin
            if ((tbl_q.a_rp[i] != '0) && (tbl_q.a_st[i] <= line_i) &&
                (!found || (tbl_q.a_st[i] >= best_st))) begin
                found   = 1'b1;
                best_st = tbl_q.a_st[i];
                rpt_o   = tbl_q.a_rp[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q         <= '0;
            tbl_q.p_rp[0] <= RW'(1);
            tbl_q.a_rp[0] <= RW'(1);
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // R10
    live_table_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(tbl_q.a_st) && $stable(tbl_q.a_rp)));
endmodule

// File: rtl/raster_line_seq.sv
module raster_line_seq #(
    parameter int LW    = 10,
    parameter int RW    = 4,
    parameter int V_VIS = 600
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    input  logic          frame_end,
    input  logic [LW-1:0] vc_i,
    input  logic [RW-1:0] rpt_i,
    output logic [LW-1:0] src_o
);
    localparam logic [LW-1:0] VIS_LINES = LW'(V_VIS);

    typedef struct packed {
        logic [LW-1:0] src;
        logic [RW-1:0] rep;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (frame_end) begin
            seq_d = '0;
        end else if (line_end && (vc_i < VIS_LINES)) begin
            if (({1'b0, seq_q.rep} + (RW+1)'(1)) >= {1'b0, rpt_i}) begin
                seq_d.src = seq_q.src + LW'(1);
                seq_d.rep = '0;
            end else begin
                seq_d.rep = seq_q.rep + RW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign src_o = seq_q.src;

    // R8
    src_step_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.src != $past(seq_q.src)) |->
            ((seq_q.src == $past(seq_q.src) + LW'(1)) || (seq_q.src == '0)));

    // R8
    src_hold_midline_chk: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(seq_q.src));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
    parameter int H_VIS  = 400,
    parameter int H_FP   = 20,
    parameter int H_SYNC = 64,
    parameter int H_BP   = 44,
    parameter int V_VIS  = 600,
    parameter int V_FP   = 1,
    parameter int V_SYNC = 4,
    parameter int V_BP   = 23,
    parameter int BANDS  = 8,
    parameter int RPT_W  = 4,
    parameter int RGB_W  = 12,
    localparam int HT    = H_VIS + H_FP + H_SYNC + H_BP,
    localparam int VT    = V_VIS + V_FP + V_SYNC + V_BP,
    localparam int HW    = $clog2(HT),
    localparam int VW    = $clog2(VT),
    localparam int BIW   = (BANDS > 1) ? $clog2(BANDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tbl_wr_i,
    input  logic [BIW-1:0]   tbl_idx_i,
    input  logic [VW-1:0]    tbl_start_i,
    input  logic [RPT_W-1:0] tbl_rpt_i,
    input  logic [RGB_W-1:0] rgb_i,
    output logic [HW-1:0]    pix_col_o,
    output logic [VW-1:0]    src_line_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             blank_o,
    output logic             frame_start_o,
    output logic [RGB_W-1:0] rgb_o
);
    import raster_pkg::*;

    localparam logic [HW-1:0] H_VIS_L = HW'(H_VIS);
    localparam logic [HW-1:0] HS_BEG  = HW'(H_VIS + H_FP);
    localparam logic [HW-1:0] HS_END  = HW'(H_VIS + H_FP + H_SYNC);
    localparam logic [VW-1:0] V_VIS_L = VW'(V_VIS);
    localparam logic [VW-1:0] VS_BEG  = VW'(V_VIS + V_FP);
    localparam logic [VW-1:0] VS_END  = VW'(V_VIS + V_FP + V_SYNC);

    logic [HW-1:0]    hc;
    logic [VW-1:0]    vc;
    logic             h_wrap, v_wrap;
    logic [RPT_W-1:0] line_rpt;

    raster_axis_counter #(.TOTAL(HT), .W(HW)) u_hcnt (
        .clk(clk), .rst(rst), .en(1'b1), .cnt_o(hc), .wrap_o(h_wrap));

    raster_axis_counter #(.TOTAL(VT), .W(VW)) u_vcnt (
        .clk(clk), .rst(rst), .en(h_wrap), .cnt_o(vc), .wrap_o(v_wrap));

    raster_band_table #(.NUM(BANDS), .LW(VW), .RW(RPT_W), .IW(BIW)) u_bands (
        .clk(clk), .rst(rst), .wr_en(tbl_wr_i), .wr_idx(tbl_idx_i),
        .wr_start(tbl_start_i), .wr_rpt(tbl_rpt_i), .commit(v_wrap),
        .line_i(vc), .rpt_o(line_rpt));

    raster_line_seq #(.LW(VW), .RW(RPT_W), .V_VIS(V_VIS)) u_seq (
        .clk(clk), .rst(rst), .line_end(h_wrap), .frame_end(v_wrap),
        .vc_i(vc), .rpt_i(line_rpt), .src_o(src_line_o));

    assign pix_col_o = hc;

    // Output alignment: stage 1 waits for the memory read, stage 2 gates colour.
    typedef struct packed {
        tim_t             t1;
        tim_t             t2;
        logic [RGB_W-1:0] rgb;
    } out_t;

    out_t out_d, out_q;
    tim_t now;

    always_comb begin
        now.hsync  = (hc >= HS_BEG) && (hc < HS_END);
        now.vsync  = (vc >= VS_BEG) && (vc < VS_END);
        now.blank  = (hc >= H_VIS_L) || (vc >= V_VIS_L);
        now.fstart = (hc == '0) && (vc == '0);
        out_d.t1   = now;
        out_d.t2   = out_q.t1;
        out_d.rgb  = rgb_i & ~{RGB_W{out_q.t1.blank}};
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign hsync_o       = out_q.t2.hsync;
    assign vsync_o       = out_q.t2.vsync;
    assign blank_o       = out_q.t2.blank;
    assign frame_start_o = out_q.t2.fstart;
    assign rgb_o         = out_q.rgb;

    // R5
    black_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        blank_o |-> rgb_o == '0);

    // R6
    single_frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> !frame_start_o);

    // R2
    hsync_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        hsync_o |-> blank_o);

    // R3
    vsync_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        vsync_o |-> blank_o);
endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
    localparam int H_VIS = 16, H_FP = 2, H_SYNC = 3, H_BP = 3;
    localparam int V_VIS = 20, V_FP = 1, V_SYNC = 2, V_BP = 2;
    localparam int HT = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int VT = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HW = $clog2(HT), VW = $clog2(VT);
    localparam int NB = 8;
    localparam int FRAME = HT * VT;

    logic clk = 1'b0, rst = 1'b1;
    logic tbl_wr_i = 1'b0;
    logic [2:0] tbl_idx_i = '0;
    logic [VW-1:0] tbl_start_i = '0;
    logic [3:0] tbl_rpt_i = '0;
    logic [11:0] rgb_i = 12'hfff;
    logic [HW-1:0] pix_col_o;
    logic [VW-1:0] src_line_o;
    logic hsync_o, vsync_o, blank_o, frame_start_o;
    logic [11:0] rgb_o;

    always #4 clk = ~clk;

    raster_timing_gen #(.H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .BANDS(NB), .RPT_W(4), .RGB_W(12)) u0 (
        .clk(clk), .rst(rst), .tbl_wr_i(tbl_wr_i), .tbl_idx_i(tbl_idx_i),
        .tbl_start_i(tbl_start_i), .tbl_rpt_i(tbl_rpt_i), .rgb_i(rgb_i),
        .pix_col_o(pix_col_o), .src_line_o(src_line_o), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .blank_o(blank_o), .frame_start_o(frame_start_o),
        .rgb_o(rgb_o));

    int checks = 0, fails = 0;
    bit done = 1'b0;
    string ln_tag = "R8";

    // Reference model state
    int m_hc = 0, m_vc = 0, m_src = 0, m_rep = 0;
    logic [3:0] m_t1 = '0, m_t2 = '0;   // {hsync, vsync, blank, fstart}
    logic [11:0] exp_rgb = '0, rgb_drv = 12'h0;
    int pst[NB], prp[NB], ast[NB], arp[NB];
    bit drv_wr = 1'b0;
    int drv_idx = 0, drv_st = 0, drv_rp = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] tim(input int hc, input int vc);
        logic [3:0] t;
        t[3] = (hc >= H_VIS + H_FP) && (hc < H_VIS + H_FP + H_SYNC);
        t[2] = (vc >= V_VIS + V_FP) && (vc < V_VIS + V_FP + V_SYNC);
        t[1] = (hc >= H_VIS) || (vc >= V_VIS);
        t[0] = (hc == 0) && (vc == 0);
        return t;
    endfunction

    function automatic int lookup(input int vc);
        int r = 1, bs = 0;
        bit f = 0;
        for (int i = 0; i < NB; i++)
            if (arp[i] != 0 && ast[i] <= vc && (!f || ast[i] >= bs)) begin
                f = 1; bs = ast[i]; r = arp[i];
            end
        return r;
    endfunction

    task automatic model_edge();
        exp_rgb = m_t1[1] ? 12'h000 : rgb_drv;
        m_t2 = m_t1;
        m_t1 = tim(m_hc, m_vc);
        if (m_hc == HT - 1) begin
            if (m_vc == VT - 1) begin
                m_src = 0; m_rep = 0;
                for (int i = 0; i < NB; i++) begin ast[i] = pst[i]; arp[i] = prp[i]; end
            end else if (m_vc < V_VIS) begin
                if (m_rep + 1 >= lookup(m_vc)) begin m_src++; m_rep = 0; end
                else m_rep++;
            end
            m_vc = (m_vc == VT - 1) ? 0 : m_vc + 1;
        end
        m_hc = (m_hc == HT - 1) ? 0 : m_hc + 1;
        if (drv_wr) begin pst[drv_idx] = drv_st; prp[drv_idx] = drv_rp; end
    endtask

    task automatic compare();
        chk(hsync_o == m_t2[3], "R2 hsync", int'(hsync_o), int'(m_t2[3]));
        chk(vsync_o == m_t2[2], "R3 vsync", int'(vsync_o), int'(m_t2[2]));
        chk(blank_o == m_t2[1], "R4 blank", int'(blank_o), int'(m_t2[1]));
        chk(frame_start_o == m_t2[0], "R6 frame_start", int'(frame_start_o), int'(m_t2[0]));
        chk(rgb_o == exp_rgb, "R5 rgb", int'(rgb_o), int'(exp_rgb));
        chk(int'(pix_col_o) == m_hc, "R7 column", int'(pix_col_o), m_hc);
        chk(int'(src_line_o) == m_src, {ln_tag, " source line"}, int'(src_line_o), m_src);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        rgb_drv = rgb_drv * 12'd5 + 12'h3a7;
        rgb_i = rgb_drv;
        drv_wr = 1'b0;
        tbl_wr_i = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) step();
    endtask

    task automatic wr(input int idx, input int st, input int rp);
        drv_wr = 1'b1; drv_idx = idx; drv_st = st; drv_rp = rp;
        tbl_wr_i = 1'b1; tbl_idx_i = 3'(idx);
        tbl_start_i = VW'(st); tbl_rpt_i = 4'(rp);
        step();
    endtask

    // R1: all outputs quiet while reset is held
    task automatic t_reset();
        repeat (3) begin
            @(negedge clk);
            chk(!hsync_o && !vsync_o && !blank_o && !frame_start_o, "R1 timing flags",
                int'({hsync_o, vsync_o, blank_o, frame_start_o}), 0);
            chk(rgb_o == '0, "R1 rgb", int'(rgb_o), 0);
            chk(pix_col_o == '0 && src_line_o == '0, "R1 addresses",
                int'({pix_col_o, src_line_o}), 0);
        end
        rst = 1'b0;
        rgb_i = rgb_drv;
    endtask

    // R8: default table, one source line per scan line
    task automatic t_default();
        ln_tag = "R8";
        run(FRAME);
    endtask

    // R10: write mid-frame, current frame must stay at repeat 1
    task automatic t_deferred();
        run(HT * 5 + 7);
        ln_tag = "R10";
        wr(0, 0, 2);
        run(FRAME - HT * 5 - 8);
        ln_tag = "R8";
        run(FRAME);
    endtask

    // R9: several bands including an equal-start tie resolved by index
    task automatic t_bands();
        ln_tag = "R10";
        wr(1, 6, 3);
        wr(2, 12, 1);
        wr(3, 12, 2);
        wr(0, 0, 1);
        ln_tag = "R9";
        run(2 * FRAME);
    endtask

    // R8: largest repeat factor
    task automatic t_max_repeat();
        ln_tag = "R10";
        wr(1, 0, 0); wr(2, 0, 0); wr(3, 0, 0);
        wr(0, 0, 15);
        ln_tag = "R8";
        run(2 * FRAME);
    endtask

    // R9: no enabled entry covers the top lines, so they use factor 1
    task automatic t_uncovered();
        ln_tag = "R10";
        wr(0, 3, 0);
        wr(4, 10, 4);
        ln_tag = "R9";
        run(2 * FRAME);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin pst[i] = 0; prp[i] = 0; ast[i] = 0; arp[i] = 0; end
        prp[0] = 1; arp[0] = 1;
        t_reset();
        t_default();
        t_deferred();
        t_bands();
        t_max_repeat();
        t_uncovered();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule